// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps the atomic reservations for a group of hardware threads that share one memory, so that load-linked / store-conditional loops can be built on top of it. Every thread port can present, in any cycle, one of three request kinds:

- a load-reserve,
- a store-conditional,
- a plain store.

Each request carries a base register number, a base value, an index value and a size flag (word or doubleword). The block forms the effective address, checks its alignment, and keeps one reservation per thread on a 128-byte line.

An external agent may also report stores through its own port. Per-thread exception and context-switch strobes wipe that thread's reservation. For every store-conditional the block returns, one cycle later, the following results:

- a completion strobe,
- a pass flag,
- a sticky condition flag (the equal bit of condition field 0),
- a memory write enable,
- an alignment-fault flag, which is also raised for misaligned load-reserves.

The current reservation state of each thread is visible on two outputs. The memory data path itself is not part of the block.

Top module: `resv_monitor`

## Requirements
- R1: After reset every thread's reservation is invalid (`rsv_valid_o` = 0), and all result strobes are 0.
- R2: A thread holds at most one reservation. An aligned load-reserve of either size replaces the earlier one. `rsv_dword_o` shows 1 when the held reservation came from a doubleword request and 0 when it came from a word request.
- R3: A reservation covers the naturally aligned 128-byte line of its address. Effective-address bits [6:0] are ignored and only bits [31:7] are compared.
- R4: A plain store or a passing store-conditional from another thread, or an external-agent store, that targets the reserved line invalidates the reservation. A store to another line does not, and neither does the thread's own plain store.
- R5: An exception or a context-switch strobe for a thread invalidates that thread's reservation. A store-conditional in the same cycle fails.
- R6: A store-conditional passes only when the thread holds a valid reservation on the target line. One cycle after the request, `done_o` pulses. `pass_o` and `mem_we_o` are 1 only on success. `cr0_eq_o` takes the pass value and holds it until the thread's next store-conditional. Plain stores also raise `mem_we_o`.
- R7: An aligned store-conditional clears the issuing thread's reservation whether it passes or fails.
- R8: A doubleword request whose address has a nonzero bit in [2:0], or a word request whose address has a nonzero bit in [1:0], sets `fault_o` one cycle later. Such a request neither sets nor consumes a reservation, and a faulting store-conditional fails.
- R9: The effective address is base + index. When the base register number is 0, the base is the constant zero whatever the base value.
- R10: When a store-conditional and another thread's plain store hit the same line in one cycle, the store wins and the conditional fails. Among passing store-conditionals to one line in one cycle, the lowest thread index wins and the others fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op_i | input | NUM_THR x 2 | Request kind per thread: 0 idle, 1 load-reserve, 2 store-conditional, 3 plain store |
| req_dword_i | input | NUM_THR | 1 = doubleword, 0 = word |
| ra_num_i | input | NUM_THR x 5 | Base register number (0 selects constant zero) |
| ra_val_i | input | NUM_THR x 32 | Base register value |
| rb_val_i | input | NUM_THR x 32 | Index register value |
| exc_i | input | NUM_THR | Exception taken by thread |
| ctx_sw_i | input | NUM_THR | Context switch on thread |
| ext_st_valid_i | input | 1 | Store by an external agent |
| ext_st_addr_i | input | 32 | Address of the external store |
| done_o | output | NUM_THR | Store-conditional result valid |
| pass_o | output | NUM_THR | Store-conditional succeeded |
| cr0_eq_o | output | NUM_THR | Sticky condition-field-0 equal bit |
| fault_o | output | NUM_THR | Alignment fault |
| mem_we_o | output | NUM_THR | Memory write enable |
| rsv_valid_o | output | NUM_THR | Thread holds a reservation |
| rsv_dword_o | output | NUM_THR | Held reservation is doubleword |

## Verification
Every result is registered once. For a request, strobe or external store presented before a clock edge:

- `done_o`, `pass_o`, `fault_o`, `mem_we_o` and `cr0_eq_o` are valid in the cycle after that edge.
- The reservation outputs take their new value in that same cycle.

The bench drives inputs just after a falling edge and samples all outputs at the next falling edge, which is exactly one rising edge later. It then clears the request before the following edge, so each strobe is seen as a single-cycle pulse. Effects on a reservation that a later store-conditional depends on are checked in the cycle after that conditional.

// File: rtl/resv_pkg.sv
package resv_pkg;
    localparam int ADDR_W   = 32;
    localparam int LINE_LSB = 7;
    localparam int REGN_W   = 5;
    localparam int LINE_W   = ADDR_W - LINE_LSB;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LRES  = 2'd1,
        OP_SCOND = 2'd2,
        OP_STORE = 2'd3
    } op_e;

    typedef struct packed {
        op_e   op;
        logic  dword;
        logic  misal;
        addr_t ea;
    } req_t;

    typedef struct packed {
        logic  valid;
        logic  dword;
        line_t line;
    } slot_t;

    function automatic line_t line_of(addr_t a);
        return a[ADDR_W-1:LINE_LSB];
    endfunction

    function automatic logic misaligned(addr_t a, logic dw);
        return dw ? (|a[2:0]) : (|a[1:0]);
    endfunction

    function automatic logic is_atomic(op_e op);
        return (op == OP_LRES) || (op == OP_SCOND);
    endfunction
endpackage

// File: rtl/resv_ea_unit.sv
module resv_ea_unit
    import resv_pkg::*;
#(
    parameter int NUM_THR = 4
) (
    input  logic [NUM_THR-1:0][1:0]        op_i,
    input  logic [NUM_THR-1:0]             dword_i,
    input  logic [NUM_THR-1:0][REGN_W-1:0] ra_num_i,
    input  logic [NUM_THR-1:0][ADDR_W-1:0] ra_val_i,
    input  logic [NUM_THR-1:0][ADDR_W-1:0] rb_val_i,
    output req_t [NUM_THR-1:0]             req_o
);
    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        addr_t base;
        addr_t ea;
        op_e   op;
        assign op   = op_e'(op_i[t]);
        assign base = (ra_num_i[t] == '0) ? '0 : ra_val_i[t];
        assign ea   = base + rb_val_i[t];
        always_comb begin
            req_o[t].op    = op;
            req_o[t].dword = dword_i[t];
            req_o[t].ea    = ea;
            req_o[t].misal = is_atomic(op) && misaligned(ea, dword_i[t]);
        end
    end
endmodule

// File: rtl/resv_resolve.sv
module resv_resolve
    import resv_pkg::*;
#(
    parameter int NUM_THR = 4
) (
    input  req_t  [NUM_THR-1:0] req_i,
    input  slot_t [NUM_THR-1:0] slot_i,
    input  logic  [NUM_THR-1:0] exc_i,
    input  logic  [NUM_THR-1:0] ctx_sw_i,
    input  logic                ext_st_valid_i,
    input  addr_t               ext_st_addr_i,
    output logic  [NUM_THR-1:0] pass_o,
    output slot_t [NUM_THR-1:0] slot_nxt_o
);
    logic [NUM_THR-1:0] plain_hit;
    logic [NUM_THR-1:0] sc_win_hit;
    logic [NUM_THR-1:0] drop;
    logic [NUM_THR-1:0] pass_c;

    // stores that do not depend on any conditional outcome
    always_comb begin
        for (int i = 0; i < NUM_THR; i++) begin
            plain_hit[i] = ext_st_valid_i && (line_of(ext_st_addr_i) == slot_i[i].line);
            for (int j = 0; j < NUM_THR; j++) begin
                if (j != i && req_i[j].op == OP_STORE &&
                    line_of(req_i[j].ea) == slot_i[i].line)
                    plain_hit[i] = 1'b1;
            end
        end
    end

    // conditionals resolved in thread order: lower index wins a line
    always_comb begin
        pass_c = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            logic lower_won;
            lower_won = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (pass_c[j] && line_of(req_i[j].ea) == slot_i[i].line)
                    lower_won = 1'b1;
            end
            pass_c[i] = (req_i[i].op == OP_SCOND) && !req_i[i].misal &&
                        slot_i[i].valid &&
                        (line_of(req_i[i].ea) == slot_i[i].line) &&
                        !plain_hit[i] && !exc_i[i] && !ctx_sw_i[i] && !lower_won;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_THR; i++) begin
            sc_win_hit[i] = 1'b0;
            for (int j = 0; j < NUM_THR; j++) begin
                if (j != i && pass_c[j] && line_of(req_i[j].ea) == slot_i[i].line)
                    sc_win_hit[i] = 1'b1;
            end
            drop[i] = plain_hit[i] || sc_win_hit[i];
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_THR; i++) begin
            slot_nxt_o[i] = slot_i[i];
            if (exc_i[i] || ctx_sw_i[i]) begin
                slot_nxt_o[i].valid = 1'b0;
            end else if (req_i[i].op == OP_LRES && !req_i[i].misal) begin
                slot_nxt_o[i].valid = 1'b1;
                slot_nxt_o[i].dword = req_i[i].dword;
                slot_nxt_o[i].line  = line_of(req_i[i].ea);
            end else if (req_i[i].op == OP_SCOND && !req_i[i].misal) begin
                slot_nxt_o[i].valid = 1'b0;
            end else if (drop[i]) begin
                slot_nxt_o[i].valid = 1'b0;
            end
        end
    end

    assign pass_o = pass_c;
endmodule

// File: rtl/resv_slot_bank.sv
module resv_slot_bank
    import resv_pkg::*;
#(
    parameter int NUM_THR = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  slot_t [NUM_THR-1:0] slot_nxt_i,
    output slot_t [NUM_THR-1:0] slot_o
);
    for (genvar t = 0; t < NUM_THR; t++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) slot_o[t] <= '0;
            else     slot_o[t] <= slot_nxt_i[t];
        end
    end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int NUM_THR = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_THR-1:0][1:0]         req_op_i,
    input  logic [NUM_THR-1:0]              req_dword_i,
    input  logic [NUM_THR-1:0][REGN_W-1:0]  ra_num_i,
    input  logic [NUM_THR-1:0][ADDR_W-1:0]  ra_val_i,
    input  logic [NUM_THR-1:0][ADDR_W-1:0]  rb_val_i,
    input  logic [NUM_THR-1:0]              exc_i,
    input  logic [NUM_THR-1:0]              ctx_sw_i,
    input  logic                            ext_st_valid_i,
    input  logic [ADDR_W-1:0]               ext_st_addr_i,
    output logic [NUM_THR-1:0]              done_o,
    output logic [NUM_THR-1:0]              pass_o,
    output logic [NUM_THR-1:0]              cr0_eq_o,
    output logic [NUM_THR-1:0]              fault_o,
    output logic [NUM_THR-1:0]              mem_we_o,
    output logic [NUM_THR-1:0]              rsv_valid_o,
    output logic [NUM_THR-1:0]              rsv_dword_o
);
    req_t  [NUM_THR-1:0] req;
    slot_t [NUM_THR-1:0] slot;
    slot_t [NUM_THR-1:0] slot_nxt;
    logic  [NUM_THR-1:0] pass_c;

    resv_ea_unit #(.NUM_THR(NUM_THR)) u_ea (
        .op_i     (req_op_i),
        .dword_i  (req_dword_i),
        .ra_num_i (ra_num_i),
        .ra_val_i (ra_val_i),
        .rb_val_i (rb_val_i),
        .req_o    (req)
    );

    resv_resolve #(.NUM_THR(NUM_THR)) u_res (
        .req_i          (req),
        .slot_i         (slot),
        .exc_i          (exc_i),
        .ctx_sw_i       (ctx_sw_i),
        .ext_st_valid_i (ext_st_valid_i),
        .ext_st_addr_i  (ext_st_addr_i),
        .pass_o         (pass_c),
        .slot_nxt_o     (slot_nxt)
    );

    resv_slot_bank #(.NUM_THR(NUM_THR)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .slot_nxt_i (slot_nxt),
        .slot_o     (slot)
    );

    for (genvar t = 0; t < NUM_THR; t++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) begin
                done_o[t]   <= 1'b0;
                pass_o[t]   <= 1'b0;
                cr0_eq_o[t] <= 1'b0;
                fault_o[t]  <= 1'b0;
                mem_we_o[t] <= 1'b0;
            end else begin
                done_o[t]   <= (req[t].op == OP_SCOND);
                pass_o[t]   <= pass_c[t];
                fault_o[t]  <= req[t].misal;
                mem_we_o[t] <= pass_c[t] || (req[t].op == OP_STORE);
                if (req[t].op == OP_SCOND)
                    cr0_eq_o[t] <= pass_c[t];
            end
        end
        assign rsv_valid_o[t] = slot[t].valid;
        assign rsv_dword_o[t] = slot[t].dword;
    end
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int NUM_THR = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_THR-1:0] exc_i,
    input logic [NUM_THR-1:0] ctx_sw_i,
    input logic [NUM_THR-1:0] done_o,
    input logic [NUM_THR-1:0] pass_o,
    input logic [NUM_THR-1:0] fault_o,
    input logic [NUM_THR-1:0] mem_we_o,
    input logic [NUM_THR-1:0] rsv_valid_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (rsv_valid_o == '0 && done_o == '0));

    for (genvar t = 0; t < NUM_THR; t++) begin : g_chk
        assert_pass_had_resv_R6: assert property (@(posedge clk) disable iff (rst)
            pass_o[t] |-> (done_o[t] && $past(rsv_valid_o[t])));
        assert_fail_no_write_R6: assert property (@(posedge clk) disable iff (rst)
            (done_o[t] && !pass_o[t]) |-> !mem_we_o[t]);
        assert_pass_consumes_R7: assert property (@(posedge clk) disable iff (rst)
            pass_o[t] |-> !rsv_valid_o[t]);
        assert_kill_on_event_R5: assert property (@(posedge clk) disable iff (rst)
            (exc_i[t] || ctx_sw_i[t]) |=> (!rsv_valid_o[t] && !pass_o[t]));
        assert_fault_no_pass_R8: assert property (@(posedge clk) disable iff (rst)
            fault_o[t] |-> !pass_o[t]);
    end
endmodule

bind resv_monitor resv_monitor_chk #(.NUM_THR(NUM_THR)) u_chk (.*);

// File: tb/tb_resv_monitor.sv
module tb_resv_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NT-1:0][1:0]    req_op;
    logic [NT-1:0]         req_dword;
    logic [NT-1:0][4:0]    ra_num;
    logic [NT-1:0][AW-1:0] ra_val;
    logic [NT-1:0][AW-1:0] rb_val;
    logic [NT-1:0]         exc;
    logic [NT-1:0]         ctx_sw;
    logic                  ext_v;
    logic [AW-1:0]         ext_a;
    logic [NT-1:0] done, pass, cr0, fault, we, rv, rdw;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    resv_monitor #(.NUM_THR(NT)) dut (
        .clk(clk), .rst(rst),
        .req_op_i(req_op), .req_dword_i(req_dword), .ra_num_i(ra_num),
        .ra_val_i(ra_val), .rb_val_i(rb_val), .exc_i(exc), .ctx_sw_i(ctx_sw),
        .ext_st_valid_i(ext_v), .ext_st_addr_i(ext_a),
        .done_o(done), .pass_o(pass), .cr0_eq_o(cr0), .fault_o(fault),
        .mem_we_o(we), .rsv_valid_o(rv), .rsv_dword_o(rdw)
    );

    localparam logic [1:0] LRES = 2'd1, SCOND = 2'd2, STORE = 2'd3;

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_op = '0; req_dword = '0; ra_num = '0; ra_val = '0; rb_val = '0;
        exc = '0; ctx_sw = '0; ext_v = 1'b0; ext_a = '0;
    endtask

    task automatic put(input int t, input logic [1:0] op, input logic dw, input logic [AW-1:0] a);
        req_op[t] = op; req_dword[t] = dw; ra_num[t] = 5'd1; ra_val[t] = a; rb_val[t] = '0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // one request on one thread, returned with outputs sampled one edge later
    task automatic one(input int t, input logic [1:0] op, input logic dw, input logic [AW-1:0] a);
        idle(); put(t, op, dw, a); tick(); idle();
    endtask

    task automatic t_reset();
        chk(rv[0] | rv[1] | rv[2] | rv[3], 1'b0, "R1 reservations after reset");
        chk(|done, 1'b0, "R1 done after reset");
        chk(|cr0, 1'b0, "R1 cr0 after reset");
    endtask

    task automatic t_basic_pass();
        one(0, LRES, 1'b1, 32'h1000);
        chk(rv[0], 1'b1, "R2 reserve set");
        chk(rdw[0], 1'b1, "R2 dword width");
        one(0, SCOND, 1'b1, 32'h1078);
        chk(done[0], 1'b1, "R6 done pulse");
        chk(pass[0], 1'b1, "R3 same-line sc passes");
        chk(cr0[0], 1'b1, "R6 cr0 set");
        chk(we[0], 1'b1, "R6 write on pass");
        chk(rv[0], 1'b0, "R7 pass clears");
        tick();
        chk(done[0], 1'b0, "R6 done single pulse");
        chk(cr0[0], 1'b1, "R6 cr0 sticky");
        one(0, SCOND, 1'b1, 32'h1000);
        chk(pass[0], 1'b0, "R6 no reservation fails");
        chk(cr0[0], 1'b0, "R6 cr0 cleared");
        chk(we[0], 1'b0, "R6 no write on fail");
    endtask

    task automatic t_line();
        one(1, LRES, 1'b0, 32'h1004);
        chk(rdw[1], 1'b0, "R2 word width");
        one(1, SCOND, 1'b0, 32'h1080);
        chk(pass[1], 1'b0, "R3 other line fails");
        chk(rv[1], 1'b0, "R7 failed sc clears");
    endtask

    task automatic t_foreign();
        one(0, LRES, 1'b1, 32'h2000);
        one(1, STORE, 1'b0, 32'h2080);
        chk(rv[0], 1'b1, "R4 store other line keeps");
        chk(we[1], 1'b1, "R6 plain store write");
        one(0, STORE, 1'b1, 32'h2008);
        chk(rv[0], 1'b1, "R4 own store keeps");
        one(1, STORE, 1'b0, 32'h207C);
        chk(rv[0], 1'b0, "R4 foreign store kills");
        one(0, SCOND, 1'b1, 32'h2000);
        chk(pass[0], 1'b0, "R4 sc after kill fails");
        one(2, LRES, 1'b1, 32'h2100);
        idle(); ext_v = 1'b1; ext_a = 32'h2140; tick(); idle();
        chk(rv[2], 1'b0, "R4 external store kills");
    endtask

    task automatic t_events();
        one(3, LRES, 1'b1, 32'h3000);
        idle(); exc[3] = 1'b1; tick(); idle();
        chk(rv[3], 1'b0, "R5 exception kills");
        one(3, LRES, 1'b1, 32'h3000);
        idle(); ctx_sw[3] = 1'b1; put(3, SCOND, 1'b1, 32'h3000); tick(); idle();
        chk(pass[3], 1'b0, "R5 sc with ctx switch fails");
        chk(rv[3], 1'b0, "R5 ctx switch kills");
    endtask

    task automatic t_align();
        one(0, LRES, 1'b1, 32'h4004);
        chk(fault[0], 1'b1, "R8 dword misaligned reserve faults");
        chk(rv[0], 1'b0, "R8 faulting reserve sets nothing");
        one(0, LRES, 1'b0, 32'h4004);
        chk(fault[0], 1'b0, "R8 word 4-aligned ok");
        chk(rv[0], 1'b1, "R8 word reserve set");
        one(0, LRES, 1'b0, 32'h5002);
        chk(fault[0], 1'b1, "R8 word misaligned faults");
        chk(rv[0], 1'b1, "R8 faulting reserve keeps old");
        one(0, SCOND, 1'b1, 32'h4004);
        chk(fault[0], 1'b1, "R8 sc misaligned faults");
        chk(pass[0], 1'b0, "R8 faulting sc fails");
        chk(rv[0], 1'b1, "R8 faulting sc keeps reservation");
        one(0, SCOND, 1'b0, 32'h4004);
        chk(pass[0], 1'b1, "R8 word sc passes after fault");
    endtask

    task automatic t_ea();
        idle(); req_op[2] = LRES; req_dword[2] = 1'b1; ra_num[2] = 5'd0;
        ra_val[2] = 32'h5000; rb_val[2] = 32'h0100; tick(); idle();
        idle(); req_op[2] = SCOND; req_dword[2] = 1'b1; ra_num[2] = 5'd3;
        ra_val[2] = 32'h0080; rb_val[2] = 32'h0080; tick(); idle();
        chk(pass[2], 1'b1, "R9 zero base register uses constant zero");
        idle(); req_op[2] = LRES; req_dword[2] = 1'b1; ra_num[2] = 5'd0;
        ra_val[2] = 32'h5000; rb_val[2] = 32'h0100; tick(); idle();
        one(2, SCOND, 1'b1, 32'h5100);
        chk(pass[2], 1'b0, "R9 base value not added");
    endtask

    task automatic t_replace();
        one(1, LRES, 1'b1, 32'h6000);
        one(1, LRES, 1'b0, 32'h7000);
        chk(rdw[1], 1'b0, "R2 replacement width");
        one(1, SCOND, 1'b1, 32'h6000);
        chk(pass[1], 1'b0, "R2 old reservation replaced");
    endtask

    task automatic t_collide();
        one(0, LRES, 1'b1, 32'h8000);
        idle(); put(0, SCOND, 1'b1, 32'h8000); put(1, STORE, 1'b1, 32'h8010); tick(); idle();
        chk(pass[0], 1'b0, "R10 store beats sc");
        idle(); put(1, LRES, 1'b1, 32'h9000); put(2, LRES, 1'b1, 32'h9008); tick(); idle();
        idle(); put(1, SCOND, 1'b1, 32'h9000); put(2, SCOND, 1'b1, 32'h9008); tick(); idle();
        chk(pass[1], 1'b1, "R10 lower thread wins");
        chk(pass[2], 1'b0, "R10 higher thread loses");
        chk(rv[2], 1'b0, "R10 loser reservation cleared");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        idle();
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_basic_pass();
        t_line();
        t_foreign();
        t_events();
        t_align();
        t_ea();
        t_replace();
        t_collide();
        summary();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end
endmodule